// File: doc/BRIEF.md
# Nonvolatile Store/Recall Controller

This block sequences copies between a volatile SRAM array and the nonvolatile cells that shadow it. A STORE copies the SRAM into the nonvolatile cells. A RECALL copies the nonvolatile cells back into the SRAM. The block picks one operation from five sources:

- a software store request
- a software recall request
- an external low on a shared open-drain busy line
- a supply drop below the switch threshold
- the supply returning above that threshold

Each operation lasts a fixed number of clock cycles. While it runs, the controller blocks SRAM accesses and turns off the data outputs. During a store it also pulls the busy line low, so that other devices on the same line can follow.

A dirty flag records whether a write was performed since the last store. Stores started from the busy line or from a supply drop run only when this flag is set. Software stores always run. An external store request does not cut in at once. A grace window lets reads in flight finish first. Any access or write attempt inside that window ends the window early. The analog threshold detection and the memory arrays sit outside this block.

Top module: `nv_xfer_ctrl`

## Requirements
- R1: While reset is held, the block is in the powered-down state: `inhibit_o`=1, `recall_o`=0 and `busy_pd_o`=0. After reset is released with `pwr_ok_i`=1, a RECALL starts automatically. It holds `recall_o`=1 for exactly RECALL_CYCLES cycles and then returns to normal operation with `inhibit_o`=0.
- R2: A one-cycle `sw_store_i` pulse in normal operation starts a STORE whatever the dirty flag says. For exactly STORE_CYCLES cycles it holds `store_o`=1, `busy_pd_o`=1, `inhibit_o`=1 and `out_hiz_o`=1.
- R3: When a STORE ends, `busy_pd_o` drops. `inhibit_o` stays 1 until `busy_line_i` is sampled high (1 = released), and returns to 0 on the cycle after that sample.
- R4: A one-cycle `sw_recall_i` pulse in normal operation runs a RECALL of RECALL_CYCLES cycles. During it `busy_pd_o`=0 and `out_hiz_o`=1.
- R5: A write request made in normal operation while the busy line is high is performed (`wr_en_o`=1) and sets the dirty flag. The flag is cleared when a STORE completes. A RECALL leaves it unchanged.
- R6: An external low on `busy_line_i` becomes a store request only after ASSERT_CYCLES consecutive low samples. The first of those samples is taken in normal operation. A shorter low pulse starts no store.
- R7: Once an external request is accepted, SRAM access continues (`inhibit_o`=0) until GRACE_CYCLES cycles after the first low sample. The store then starts. If `acc_evt_i` is asserted after the request is accepted, the store starts on the next cycle instead. An `acc_evt_i` seen before acceptance has no effect.
- R8: A write request while `busy_line_i` is low is not performed (`wr_en_o`=0). If the external request has already been accepted, the store starts on the next cycle.
- R9: An accepted external request with the dirty flag clear runs no STORE. The block still stays inhibited until the busy line is sampled high.
- R10: When `pwr_ok_i` drops with the dirty flag set, the block pulls the busy line low and starts a STORE as soon as the line is sampled low. When it drops with the dirty flag clear, no STORE runs and the block stays inhibited.
- R11: If the line is not sampled low within PROBE_CYCLES cycles of the pull, the automatic store is abandoned. `busy_pd_o` drops, no STORE runs and the dirty flag is kept.
- R12: While `pwr_ok_i`=0 outside a running operation, software and external store requests are ignored. Each rise of `pwr_ok_i` starts a new RECALL. A RECALL started by a power-up is cut short by a supply drop, and a fresh one follows the next rise.
- R13: A software-started STORE or RECALL runs its full length. It ignores `pwr_ok_i` and every other input while it runs.
- R14: `out_hiz_o` is 1 whenever `inhibit_o` is 1 or a write is being requested. Otherwise it is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pwr_ok_i | input | 1 | Supply above switch threshold |
| sw_store_i | input | 1 | Software store request pulse |
| sw_recall_i | input | 1 | Software recall request pulse |
| busy_line_i | input | 1 | Sensed level of the shared busy line, 1 = released |
| acc_evt_i | input | 1 | Address or control transition on the SRAM port |
| wr_req_i | input | 1 | SRAM write request |
| busy_pd_o | output | 1 | Pull-down enable for the busy line |
| inhibit_o | output | 1 | Blocks SRAM read and write |
| out_hiz_o | output | 1 | Puts the data outputs in high impedance |
| store_o | output | 1 | Store strobe to the arrays |
| recall_o | output | 1 | Recall strobe to the arrays |
| wr_en_o | output | 1 | Write performed into the SRAM |

## Verification
If the dirty flag holds a wrong value, the damage shows at a store decision. An automatic or line-triggered store is then either missing or runs a full STORE_CYCLES window of `store_o` when it should not. This can be long after the write that set the flag, so the bench always drives the decision point right after each write or store.

A phase counter that is off by one moves the edge of `store_o` or `recall_o`, or the end of the grace window, by one cycle. The bench counts strobe cycles and the cycle at which each store begins.

A state that does not wait for the line to be sampled high releases `inhibit_o` one cycle after the store ends. The bench catches this while the line is still held low.

// File: rtl/nvc_pkg.sv
package nvc_pkg;

  typedef enum logic [2:0] {
    S_DOWN   = 3'd0,
    S_RECALL = 3'd1,
    S_IDLE   = 3'd2,
    S_EXT    = 3'd3,
    S_STORE  = 3'd4,
    S_WAIT   = 3'd5,
    S_PROBE  = 3'd6
  } nvc_state_e;

  typedef struct packed {
    logic busy_pd;
    logic inhibit;
    logic store;
    logic recall;
  } nvc_ctl_t;

  function automatic int nvc_max(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  function automatic nvc_ctl_t nvc_decode(input nvc_state_e s);
    nvc_ctl_t c;
    c = '0;
    unique case (s)
      S_DOWN:   c.inhibit = 1'b1;
      S_RECALL: begin c.inhibit = 1'b1; c.recall = 1'b1; end
      S_IDLE:   c = '0;
      S_EXT:    c = '0;
      S_STORE:  begin c.inhibit = 1'b1; c.store = 1'b1; c.busy_pd = 1'b1; end
      S_WAIT:   c.inhibit = 1'b1;
      S_PROBE:  begin c.inhibit = 1'b1; c.busy_pd = 1'b1; end
      default:  c.inhibit = 1'b1;
    endcase
    return c;
  endfunction

endpackage

// File: rtl/nvc_phase_cnt.sv
// Cycles spent in the current state; cleared on every state change, saturates.
module nvc_phase_cnt #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  output logic [CNT_W-1:0] cnt_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_o <= '0;
    else if (clr_i)           cnt_o <= '0;
    else if (cnt_o != '1)     cnt_o <= cnt_o + 1'b1;
  end

endmodule

// File: rtl/nvc_dirty.sv
// R5: set by a performed write, cleared by a completed store.
module nvc_dirty (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic dirty_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     dirty_o <= 1'b0;
    else if (clr_i)  dirty_o <= 1'b0;
    else if (set_i)  dirty_o <= 1'b1;
  end

endmodule

// File: rtl/nvc_seq_fsm.sv
module nvc_seq_fsm
  import nvc_pkg::*;
#(
  parameter int STORE_CYCLES  = 500000,
  parameter int RECALL_CYCLES = 1000,
  parameter int ASSERT_CYCLES = 13,
  parameter int GRACE_CYCLES  = 50,
  parameter int PROBE_CYCLES  = 3,
  parameter int CNT_W         = 19
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pwr_ok_i,
  input  logic             sw_store_i,
  input  logic             sw_recall_i,
  input  logic             busy_line_i,
  input  logic             acc_evt_i,
  input  logic             wr_req_i,
  input  logic             dirty_i,
  input  logic [CNT_W-1:0] cnt_i,
  output nvc_state_e       state_o,
  output logic             cnt_clr_o,
  output logic             store_done_o
);

  localparam logic [CNT_W-1:0] StoreLast  = CNT_W'(STORE_CYCLES - 1);
  localparam logic [CNT_W-1:0] RecallLast = CNT_W'(RECALL_CYCLES - 1);
  localparam logic [CNT_W-1:0] QualIdx    = CNT_W'(ASSERT_CYCLES - 1);
  localparam logic [CNT_W-1:0] GraceLast  = CNT_W'(GRACE_CYCLES - 1);
  localparam logic [CNT_W-1:0] ProbeLast  = CNT_W'(PROBE_CYCLES - 1);

  nvc_state_e state_q, state_d;
  logic       rc_sw_q, rc_sw_d;
  logic       qual;
  nvc_state_e fail_tgt;
  nvc_state_e ext_tgt;

  // cnt counts EXT cycles; the IDLE sample that entered EXT was the first low one
  assign qual     = (cnt_i >= QualIdx);
  // R10: a supply drop probes the line only if there is data to save
  assign fail_tgt = dirty_i ? S_PROBE : S_DOWN;
  // R9: a clean flag skips the store but still waits for the line
  assign ext_tgt  = dirty_i ? S_STORE : S_WAIT;

  always_comb begin
    state_d      = state_q;
    rc_sw_d      = rc_sw_q;
    store_done_o = 1'b0;
    unique case (state_q)
      S_DOWN: begin
        // R12: each rise of the supply starts a recall
        if (pwr_ok_i) begin
          state_d = S_RECALL;
          rc_sw_d = 1'b0;
        end
      end
      S_RECALL: begin
        // R13: a software recall ignores the supply; R12 otherwise
        if (!rc_sw_q && !pwr_ok_i) state_d = S_DOWN;
        else if (cnt_i == RecallLast) state_d = S_IDLE;
      end
      S_IDLE: begin
        if (!pwr_ok_i) state_d = fail_tgt;
        else if (sw_store_i) state_d = S_STORE;
        else if (sw_recall_i) begin
          state_d = S_RECALL;
          rc_sw_d = 1'b1;
        end
        else if (!busy_line_i) state_d = S_EXT;
      end
      S_EXT: begin
        if (!pwr_ok_i) state_d = fail_tgt;
        else if (!qual) begin
          if (busy_line_i) state_d = S_IDLE;      // R6: pulse too short
        end
        else if (acc_evt_i || wr_req_i || (cnt_i >= GraceLast)) begin
          state_d = ext_tgt;                        // R7, R8
        end
      end
      S_STORE: begin
        if (cnt_i == StoreLast) begin
          state_d      = S_WAIT;
          store_done_o = 1'b1;
        end
      end
      S_WAIT: begin
        // R3: held inhibited until the line is seen released
        if (!pwr_ok_i) state_d = fail_tgt;
        else if (busy_line_i) state_d = S_IDLE;
      end
      S_PROBE: begin
        // R11: line never went low, give up on the automatic store
        if (!busy_line_i) state_d = S_STORE;
        else if (cnt_i >= ProbeLast) state_d = S_DOWN;
      end
      default: state_d = S_DOWN;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_DOWN;
      rc_sw_q <= 1'b0;
    end else begin
      state_q <= state_d;
      rc_sw_q <= rc_sw_d;
    end
  end

  assign state_o   = state_q;
  assign cnt_clr_o = (state_d != state_q);

endmodule

// File: rtl/nv_xfer_ctrl.sv
module nv_xfer_ctrl
  import nvc_pkg::*;
#(
  parameter int STORE_CYCLES  = 500000,
  parameter int RECALL_CYCLES = 1000,
  parameter int ASSERT_CYCLES = 13,
  parameter int GRACE_CYCLES  = 50,
  parameter int PROBE_CYCLES  = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pwr_ok_i,
  input  logic sw_store_i,
  input  logic sw_recall_i,
  input  logic busy_line_i,
  input  logic acc_evt_i,
  input  logic wr_req_i,
  output logic busy_pd_o,
  output logic inhibit_o,
  output logic out_hiz_o,
  output logic store_o,
  output logic recall_o,
  output logic wr_en_o
);

  localparam int MaxCyc = nvc_max(nvc_max(STORE_CYCLES, RECALL_CYCLES),
                                  nvc_max(GRACE_CYCLES, nvc_max(ASSERT_CYCLES, PROBE_CYCLES)));
  localparam int CntW   = $clog2(MaxCyc + 1);

  nvc_state_e     state;
  logic           cnt_clr;
  logic           store_done;
  logic           dirty;
  logic [CntW-1:0] cnt;
  nvc_ctl_t       ctl;

  nvc_phase_cnt #(.CNT_W(CntW)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (cnt_clr),
    .cnt_o  (cnt)
  );

  nvc_dirty u_dirty (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .set_i   (wr_en_o),
    .clr_i   (store_done),
    .dirty_o (dirty)
  );

  nvc_seq_fsm #(
    .STORE_CYCLES  (STORE_CYCLES),
    .RECALL_CYCLES (RECALL_CYCLES),
    .ASSERT_CYCLES (ASSERT_CYCLES),
    .GRACE_CYCLES  (GRACE_CYCLES),
    .PROBE_CYCLES  (PROBE_CYCLES),
    .CNT_W         (CntW)
  ) u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .pwr_ok_i     (pwr_ok_i),
    .sw_store_i   (sw_store_i),
    .sw_recall_i  (sw_recall_i),
    .busy_line_i  (busy_line_i),
    .acc_evt_i    (acc_evt_i),
    .wr_req_i     (wr_req_i),
    .dirty_i      (dirty),
    .cnt_i        (cnt),
    .state_o      (state),
    .cnt_clr_o    (cnt_clr),
    .store_done_o (store_done)
  );

  assign ctl       = nvc_decode(state);
  assign busy_pd_o = ctl.busy_pd;
  assign inhibit_o = ctl.inhibit;
  assign store_o   = ctl.store;
  assign recall_o  = ctl.recall;
  // R8: no write once the line is low, even inside the grace window
  assign wr_en_o   = wr_req_i && busy_line_i && (state == S_IDLE);
  // R14
  assign out_hiz_o = ctl.inhibit || wr_req_i;

endmodule

// File: rtl/nv_xfer_ctrl_chk.sv
module nv_xfer_ctrl_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic busy_line_i,
  input logic busy_pd_o,
  input logic inhibit_o,
  input logic out_hiz_o,
  input logic store_o,
  input logic recall_o,
  input logic wr_en_o
);

  assert_store_holds_line_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    store_o |-> (busy_pd_o && inhibit_o && out_hiz_o));

  assert_inhibit_after_store_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(store_o) |-> (inhibit_o && !busy_pd_o));

  assert_recall_quiet_line_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    recall_o |-> (!busy_pd_o && !store_o && out_hiz_o));

  assert_write_only_active_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> !inhibit_o);

  assert_no_write_line_low_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_line_i |-> !wr_en_o);

endmodule

bind nv_xfer_ctrl nv_xfer_ctrl_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .busy_line_i (busy_line_i),
  .busy_pd_o   (busy_pd_o),
  .inhibit_o   (inhibit_o),
  .out_hiz_o   (out_hiz_o),
  .store_o     (store_o),
  .recall_o    (recall_o),
  .wr_en_o     (wr_en_o)
);

// File: tb/nv_xfer_ctrl_test.sv
`timescale 1ns/1ps
module nv_xfer_ctrl_test;

  localparam int StoreN  = 40;
  localparam int RecallN = 20;
  localparam int AssertN = 4;
  localparam int GraceN  = 12;
  localparam int ProbeN  = 3;

  typedef struct packed {
    int len;
    int wr;
    int exp_st;
  } vec_t;

  // external low pulse length, write before, expected store cycles
  localparam vec_t Vecs [6] = '{
    '{2, 1, 0}, '{3, 1, 0}, '{4, 1, StoreN},
    '{4, 0, 0}, '{8, 1, StoreN}, '{20, 1, StoreN}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pwr_ok = 1'b1;
  logic sw_store = 1'b0, sw_recall = 1'b0;
  logic acc_evt = 1'b0, wr_req = 1'b0;
  logic ext_low = 1'b0, force_high = 1'b0;
  logic busy_line;
  logic busy_pd, inhibit, out_hiz, store, recall, wr_en;

  int n_chk = 0, n_bad = 0;
  int st_cnt = 0, rc_cnt = 0, pd_cnt = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  // open-drain line: low if anyone pulls, unless a strong driver overrides
  assign busy_line = force_high ? 1'b1 : !(busy_pd || ext_low);

  nv_xfer_ctrl #(
    .STORE_CYCLES (StoreN), .RECALL_CYCLES (RecallN), .ASSERT_CYCLES (AssertN),
    .GRACE_CYCLES (GraceN), .PROBE_CYCLES (ProbeN)
  ) uut (
    .clk_i (clk), .rst_ni (rst_n), .pwr_ok_i (pwr_ok),
    .sw_store_i (sw_store), .sw_recall_i (sw_recall), .busy_line_i (busy_line),
    .acc_evt_i (acc_evt), .wr_req_i (wr_req),
    .busy_pd_o (busy_pd), .inhibit_o (inhibit), .out_hiz_o (out_hiz),
    .store_o (store), .recall_o (recall), .wr_en_o (wr_en)
  );

  always @(posedge clk) begin
    #5;
    if (store)   st_cnt++;
    if (recall)  rc_cnt++;
    if (busy_pd) pd_cnt++;
  end

  task automatic check(input string rq, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clr_cnt();
    st_cnt = 0; rc_cnt = 0; pd_cnt = 0;
  endtask

  task automatic do_write(input string rq);
    @(negedge clk); wr_req = 1'b1; #1;
    check(rq, int'(wr_en), 1);
    @(negedge clk); wr_req = 1'b0;
  endtask

  task automatic pulse_sw(input bit is_store);
    @(negedge clk);
    if (is_store) sw_store = 1'b1; else sw_recall = 1'b1;
    @(negedge clk);
    sw_store = 1'b0; sw_recall = 1'b0;
  endtask

  // holds the line low from the current negedge; returns the negedge index of the first store cycle
  task automatic grace_run(input int acc_at, input int wr_at, output int first, output int inh12);
    first = 0; inh12 = -1;
    ext_low = 1'b1;
    for (int k = 1; k <= 30; k++) begin
      @(negedge clk);
      if (first == 0 && store) first = k;
      if (k == 12) inh12 = int'(inhibit);
      acc_evt = (k == acc_at);
      wr_req  = (k == wr_at);
      if (k == wr_at) begin #1; check("R8 write while line low", int'(wr_en), 0); end
    end
    @(negedge clk); ext_low = 1'b0; acc_evt = 1'b0; wr_req = 1'b0;
    step(60);
  endtask

  initial begin
    #(20 * 100000);
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int first, inh;
    // R1 reset state
    step(3);
    check("R1 inhibit in reset", int'(inhibit), 1);
    check("R1 no recall in reset", int'(recall), 0);
    check("R1 no pull in reset", int'(busy_pd), 0);
    clr_cnt();
    rst_n = 1'b1;
    step(30);
    check("R1 power-up recall length", rc_cnt, RecallN);
    check("R1 active after recall", int'(inhibit), 0);
    check("R1 line not pulled in recall", pd_cnt, 0);

    // table: external pulses (R6, R9)
    foreach (Vecs[i]) begin
      if (Vecs[i].wr != 0) do_write("R5 write performed");
      clr_cnt();
      @(negedge clk); ext_low = 1'b1;
      step(Vecs[i].len);
      ext_low = 1'b0;
      step(70);
      check($sformatf("R6 pulse %0d store cycles", Vecs[i].len), st_cnt, Vecs[i].exp_st);
      check("R9 back to active", int'(inhibit), 0);
    end

    // R2 software store, flag clear
    clr_cnt();
    pulse_sw(1'b1);
    step(5);
    check("R2 store strobe", int'(store), 1);
    check("R2 pull during store", int'(busy_pd), 1);
    check("R14 hiz during store", int'(out_hiz), 1);
    step(45);
    check("R2 store length", st_cnt, StoreN);
    check("R2 pull length", pd_cnt, StoreN);

    // R3 inhibited until line high
    clr_cnt();
    pulse_sw(1'b1);
    ext_low = 1'b1;
    step(45);
    check("R3 inhibited while line held", int'(inhibit), 1);
    check("R3 pull released", int'(busy_pd), 0);
    ext_low = 1'b0;
    step(1);
    check("R3 active after line high", int'(inhibit), 0);

    // R14 hiz on write request
    check("R14 hiz idle", int'(out_hiz), 0);
    @(negedge clk); wr_req = 1'b1; #1;
    check("R14 hiz on write", int'(out_hiz), 1);
    @(negedge clk); wr_req = 1'b0;   // this write made the flag dirty (R5)

    // R4 software recall keeps flag; R10 power fail stores
    clr_cnt();
    pulse_sw(1'b0);
    step(3);
    check("R4 no pull in recall", int'(busy_pd), 0);
    check("R4 hiz in recall", int'(out_hiz), 1);
    step(25);
    check("R4 recall length", rc_cnt, RecallN);
    clr_cnt();
    @(negedge clk); pwr_ok = 1'b0;
    step(50);
    check("R5 flag survives recall, R10 power-fail store", st_cnt, StoreN);
    check("R10 pull includes probe", pd_cnt, StoreN + 1);
    check("R10 inhibited while down", int'(inhibit), 1);
    clr_cnt();
    @(negedge clk); pwr_ok = 1'b1;
    step(25);
    check("R12 recall on rise", rc_cnt, RecallN);

    // R10 clean power fail: no store
    clr_cnt();
    @(negedge clk); pwr_ok = 1'b0;
    step(50);
    check("R10 clean drop no store", st_cnt, 0);
    check("R10 clean drop no pull", pd_cnt, 0);
    check("R10 clean drop inhibited", int'(inhibit), 1);
    // R12 requests blocked while down
    pulse_sw(1'b1);
    ext_low = 1'b1; step(20); ext_low = 1'b0;
    step(50);
    check("R12 blocked while down", st_cnt, 0);
    // R12 recall restarts on dip
    clr_cnt();
    @(negedge clk); pwr_ok = 1'b1;
    step(5);
    pwr_ok = 1'b0;
    step(2);
    check("R12 recall cut by dip", int'(recall), 0);
    clr_cnt();
    pwr_ok = 1'b1;
    step(25);
    check("R12 recall restarted", rc_cnt, RecallN);

    // R11 abandon
    do_write("R5 write performed");
    clr_cnt();
    force_high = 1'b1;
    @(negedge clk); pwr_ok = 1'b0;
    step(50);
    check("R11 abandoned no store", st_cnt, 0);
    check("R11 pull only for probe", pd_cnt, ProbeN);
    force_high = 1'b0;
    @(negedge clk); pwr_ok = 1'b1;
    step(25);
    clr_cnt();
    @(negedge clk); pwr_ok = 1'b0;
    step(50);
    check("R11 flag kept after abandon", st_cnt, StoreN);
    @(negedge clk); pwr_ok = 1'b1;
    step(25);

    // R7 grace window
    do_write("R5 write performed");
    grace_run(2, 0, first, inh);
    check("R7 store at end of grace", first, GraceN + 1);
    check("R7 active inside grace", inh, 0);
    do_write("R5 write performed");
    grace_run(6, 0, first, inh);
    check("R7 access cuts grace", first, 7);
    do_write("R5 write performed");
    grace_run(0, 6, first, inh);
    check("R8 write starts store", first, 7);

    // R9 clean request with line held
    clr_cnt();
    @(negedge clk); ext_low = 1'b1;
    step(15);
    check("R9 inhibited after skip", int'(inhibit), 1);
    step(5); ext_low = 1'b0;
    step(2);
    check("R9 no store when clean", st_cnt, 0);
    check("R9 active after release", int'(inhibit), 0);

    // R13 software recall ignores a supply dip
    clr_cnt();
    pulse_sw(1'b0);
    step(3); pwr_ok = 1'b0; step(2); pwr_ok = 1'b1;
    step(25);
    check("R13 recall ran through dip", rc_cnt, RecallN);
    do_write("R5 write performed");
    clr_cnt();
    pulse_sw(1'b1);
    step(3); pwr_ok = 1'b0; step(2); pwr_ok = 1'b1;
    step(45);
    check("R13 store ran through dip", st_cnt, StoreN);
    check("R13 active after store", int'(inhibit), 0);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule